// File: doc/BRIEF.md
# Keyed Nonvolatile Write-Unlock Controller

This block is the control-register front end of a nonvolatile memory. Software reaches it over a byte-wide register bus with two locations: a control/status register and a key location that has no storage and only watches the bytes written to it. A program operation starts only after two consecutive key writes, 0x55 then 0xAA, and then a write of the start bit to the control register. The write-enable bit must already be set for all of these writes. A program operation never starts from a single stray write.

Once it is armed and started, the block runs a timed program operation. A counter of `PROG_CYCLES` clocks stands in for the array's program time. The block holds `cpuStall` for the whole operation. At the end it clears the start bit and raises a completion flag.

Three reset sources are kept apart. An asynchronous power-on/brown-out reset clears everything. Synchronous external and watchdog resets are warm: they keep the two space-select bits and the error flag, and clear the rest. A warm reset that lands during an operation aborts it and sets the error flag.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: The control register sits at address 0 with this layout: bit 7 memory-space select, bit 6 configuration-space select, bit 5 always reads 0, bit 4 erase request, bit 3 write-error flag, bit 2 write enable, bit 1 write start, bit 0 read start. Address 1 is the key location and reads as 0x00.
- R2: While `rstPorN` is low the control register reads 0x00, and `cpuStall` and `doneIrq` are 0.
- R3: A start is accepted only if the two writes just before it were key writes of 0x55 and then 0xAA. The start itself is a control write with bits 1 and 2 set. Any other write in between, or a wrong key byte, returns the detector to idle.
- R4: Key writes have no effect unless the stored write-enable bit (bit 2) is 1.
- R5: A control write with bit 1 set that is not accepted as a start is ignored as a whole, and the register keeps its value.
- R6: After an accepted start, `cpuStall` and bit 1 are high for exactly `PROG_CYCLES` clocks. Then both clear, and `doneIrq` rises on the same edge.
- R7: Register writes are ignored while `cpuStall` is high.
- R8: An external or watchdog reset during an operation ends the stall at once, sets bit 3, keeps bits 7 and 6, and clears bits 4, 2, 1 and 0.
- R9: An external or watchdog reset while idle keeps bits 7, 6 and 3 and clears bits 4, 2, 1 and 0.
- R10: A write that sets bit 0 is visible for one clock, after which hardware clears bit 0.
- R11: `doneIrq` stays set until a new start is accepted or any reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Asynchronous active-low power-on/brown-out reset |
| extRst | input | 1 | Synchronous external (warm) reset, active high |
| wdtRst | input | 1 | Synchronous watchdog (warm) reset, active high |
| regAddr | input | ADDR_W | Register address: 0 = control, 1 = key |
| regWr | input | 1 | Write strobe, one byte per clock |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| cpuStall | output | 1 | High for the whole program operation |
| doneIrq | output | 1 | Completion interrupt flag |

## Verification
A write strobe presented before a rising edge takes effect on that edge. The register, `cpuStall` and `doneIrq` are therefore valid at the next falling edge, and read data follows `regAddr` combinationally. A read-start bit lives for exactly one further clock, and a warm reset shows its result one edge after the pulse. Each bench task drives inputs on a falling edge and samples outputs on the falling edge after the capturing rising edge. The stall length is measured by counting falling edges with `cpuStall` high, which must equal `PROG_CYCLES` and be followed directly by the completion flag.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int unsigned BIT_MEM   = 7;
  localparam int unsigned BIT_CFG   = 6;
  localparam int unsigned BIT_ERASE = 4;
  localparam int unsigned BIT_ERR   = 3;
  localparam int unsigned BIT_EN    = 2;
  localparam int unsigned BIT_GO    = 1;
  localparam int unsigned BIT_RD    = 0;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } keyState_t;

  typedef struct packed {
    logic ctrlWr;   // accepted control write
    logic startWr;  // accepted write that starts an operation
    logic finish;   // program time elapsed
    logic warmRst;  // external or watchdog reset
    logic abort;    // warm reset hit a running operation
  } ctrlStrobe_t;
endpackage

// File: rtl/nvm_unlock_ctl.sv
module nvm_unlock_ctl
  import nvm_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned KEY_ADDR    = 1,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              extRst,
  input  logic              wdtRst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWrData,
  input  logic              wrEnQ,
  output ctrlStrobe_t       strb,
  output logic              busyQ
);
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  keyState_t keyQ, keyD;
  logic [CNT_W-1:0] progCnt;
  logic isCtrl, isKey, startReq, armed, startOk;

  always_comb begin
    isCtrl   = regWr && (regAddr == ADDR_W'(CTRL_ADDR));
    isKey    = regWr && (regAddr == ADDR_W'(KEY_ADDR));
    startReq = isCtrl && regWrData[BIT_GO];
    armed    = (keyQ == KEY_ARMED) && wrEnQ;
    startOk  = startReq && armed && regWrData[BIT_EN];

    strb.warmRst = extRst || wdtRst;
    strb.abort   = strb.warmRst && busyQ;
    strb.ctrlWr  = isCtrl && !busyQ && !strb.warmRst && (!startReq || startOk);
    strb.startWr = strb.ctrlWr && startReq;
    strb.finish  = busyQ && (progCnt == CNT_LAST) && !strb.warmRst;
  end

  always_comb begin
    keyD = keyQ;
    if (strb.warmRst || busyQ) begin
      keyD = KEY_IDLE;
    end else if (regWr) begin
      keyD = KEY_IDLE;
      if (isKey && wrEnQ) begin
        unique case (keyQ)
          KEY_IDLE: if (regWrData == KEY_FIRST)  keyD = KEY_HALF;
          KEY_HALF: if (regWrData == KEY_SECOND) keyD = KEY_ARMED;
          default:  keyD = KEY_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      keyQ    <= KEY_IDLE;
      busyQ   <= 1'b0;
      progCnt <= '0;
    end else begin
      keyQ <= keyD;
      if (strb.warmRst) begin
        busyQ   <= 1'b0;
        progCnt <= '0;
      end else if (strb.startWr) begin
        busyQ   <= 1'b1;
        progCnt <= '0;
      end else if (busyQ) begin
        if (progCnt == CNT_LAST) begin
          busyQ   <= 1'b0;
          progCnt <= '0;
        end else begin
          progCnt <= progCnt + 1'b1;
        end
      end
    end
  end

  // R3
  arm_before_start_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(busyQ) |-> $past(keyQ == KEY_ARMED));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    busyQ && (progCnt != CNT_LAST) && !strb.warmRst |=> busyQ);

  // R8
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    strb.warmRst |=> !busyQ);
endmodule

// File: rtl/nvm_unlock_dp.sv
module nvm_unlock_dp
  import nvm_unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstPorN,
  input  logic [7:0]  regWrData,
  input  ctrlStrobe_t strb,
  input  logic        busyIn,
  output logic [7:0]  ctrlQ,
  output logic        doneQ
);
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      ctrlQ <= '0;
      doneQ <= 1'b0;
    end else if (strb.warmRst) begin
      ctrlQ <= {ctrlQ[BIT_MEM], ctrlQ[BIT_CFG], 2'b00,
                ctrlQ[BIT_ERR] | strb.abort, 3'b000};
      doneQ <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        ctrlQ <= {regWrData[BIT_MEM], regWrData[BIT_CFG], 1'b0,
                  regWrData[BIT_ERASE], regWrData[BIT_ERR], regWrData[BIT_EN],
                  strb.startWr, regWrData[BIT_RD]};
      end else begin
        if (strb.finish)   ctrlQ[BIT_GO] <= 1'b0;
        if (ctrlQ[BIT_RD]) ctrlQ[BIT_RD] <= 1'b0;
      end
      if (strb.startWr)     doneQ <= 1'b0;
      else if (strb.finish) doneQ <= 1'b1;
    end
  end

  // R8
  err_on_abort_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    strb.abort |=> ctrlQ[BIT_ERR]);

  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    busyIn && !strb.warmRst |=> $stable(ctrlQ[7:2]));

  // R10
  rd_selfclear_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    ctrlQ[BIT_RD] && !strb.ctrlWr |=> !ctrlQ[BIT_RD]);
endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned KEY_ADDR    = 1,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              extRst,
  input  logic              wdtRst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              cpuStall,
  output logic              doneIrq
);
  ctrlStrobe_t strb;
  logic [7:0]  ctrlQ;
  logic        busyQ;

  nvm_unlock_ctl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_ctl (
    .clk(clk), .rstPorN(rstPorN), .extRst(extRst), .wdtRst(wdtRst),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .wrEnQ(ctrlQ[BIT_EN]), .strb(strb), .busyQ(busyQ)
  );

  nvm_unlock_dp u_dp (
    .clk(clk), .rstPorN(rstPorN), .regWrData(regWrData), .strb(strb),
    .busyIn(busyQ), .ctrlQ(ctrlQ), .doneQ(doneIrq)
  );

  assign cpuStall  = busyQ;
  assign regRdData = (regAddr == ADDR_W'(CTRL_ADDR)) ? ctrlQ : 8'h00;

  // R6
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    $fell(cpuStall) && !$past(extRst || wdtRst) |-> doneIrq);

  // R5
  no_blind_start_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(cpuStall) |-> $past(regWr && regWrData[BIT_GO] && regWrData[BIT_EN]));
endmodule

// File: tb/nvm_unlock_ctrl_bench.sv
module nvm_unlock_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned PROG = 8;

  logic clk = 1'b0, rstPorN = 1'b0, extRst = 1'b0, wdtRst = 1'b0;
  logic [0:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic cpuStall, doneIrq;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_unlock_ctrl #(.PROG_CYCLES(PROG)) u_nvm_unlock_ctrl (
    .clk(clk), .rstPorN(rstPorN), .extRst(extRst), .wdtRst(wdtRst),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuStall(cpuStall), .doneIrq(doneIrq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [0:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  function automatic logic [7:0] rdNow(logic [0:0] a);
    regAddr = a;
    return regRdData;
  endfunction

  task automatic readCtrl(string req, logic [7:0] exp);
    regAddr = 1'b0; #1;
    check(req, regRdData, exp);
  endtask

  task automatic unlockKeys();
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'hAA);
  endtask

  task automatic warmPulse(bit wdt);
    if (wdt) wdtRst = 1'b1; else extRst = 1'b1;
    @(negedge clk);
    wdtRst = 1'b0; extRst = 1'b0;
  endtask

  task automatic testReset();
    readCtrl("R2 ctrl", 8'h00);
    check("R2 stall", {7'b0, cpuStall}, 8'h00);
    check("R2 done", {7'b0, doneIrq}, 8'h00);
    regAddr = 1'b1; #1;
    check("R1 key reads zero", regRdData, 8'h00);
  endtask

  task automatic testLayoutAndRead();
    wrReg(1'b0, 8'hF5);
    readCtrl("R1 bit5 zero, R10 read visible", 8'hD5);
    @(negedge clk);
    readCtrl("R10 read self-clears", 8'hD4);
    wrReg(1'b0, 8'h04);
    readCtrl("R1 enable stored", 8'h04);
  endtask

  task automatic testNoKey();
    wrReg(1'b0, 8'hC6);
    readCtrl("R5 blind start ignored", 8'h04);
    check("R5 no stall", {7'b0, cpuStall}, 8'h00);
  endtask

  task automatic testGoodWrite();
    int n = 0;
    unlockKeys();
    wrReg(1'b0, 8'h86);
    readCtrl("R6 start bit set", 8'h86);
    while (cpuStall && n < 100) begin n++; @(negedge clk); end
    check("R6 stall length", 8'(n), 8'(PROG));
    check("R6 done raised", {7'b0, doneIrq}, 8'h01);
    readCtrl("R6 start bit cleared", 8'h84);
  endtask

  task automatic testBrokenKeys();
    wrReg(1'b0, 8'h04);
    wrReg(1'b1, 8'h55); wrReg(1'b1, 8'h12); wrReg(1'b1, 8'hAA);
    wrReg(1'b0, 8'h06);
    check("R3 wrong byte", {7'b0, cpuStall}, 8'h00);
    wrReg(1'b1, 8'h55); wrReg(1'b0, 8'h04); wrReg(1'b1, 8'hAA);
    wrReg(1'b0, 8'h06);
    check("R3 interleaved write", {7'b0, cpuStall}, 8'h00);
    readCtrl("R5 register unchanged", 8'h04);
    wrReg(1'b0, 8'h00);
    unlockKeys();
    wrReg(1'b0, 8'h06);
    check("R4 keys need enable", {7'b0, cpuStall}, 8'h00);
    readCtrl("R4 register unchanged", 8'h00);
  endtask

  task automatic testBusyWrites();
    wrReg(1'b0, 8'h04);
    unlockKeys();
    wrReg(1'b0, 8'h06);
    check("R11 done cleared by new start", {7'b0, doneIrq}, 8'h00);
    wrReg(1'b0, 8'h00);
    readCtrl("R7 write ignored while busy", 8'h06);
    repeat (PROG) @(negedge clk);
    readCtrl("R7 enable survives busy write", 8'h04);
    check("R11 done held", {7'b0, doneIrq}, 8'h01);
  endtask

  task automatic testAbort(bit wdt);
    wrReg(1'b0, 8'hC4);
    unlockKeys();
    wrReg(1'b0, 8'hC6);
    repeat (3) @(negedge clk);
    warmPulse(wdt);
    readCtrl(wdt ? "R8 watchdog abort" : "R8 external abort", 8'hC8);
    check("R8 stall ends", {7'b0, cpuStall}, 8'h00);
  endtask

  task automatic testWarmIdle();
    wrReg(1'b0, 8'hDD);
    @(negedge clk);
    warmPulse(1'b0);
    readCtrl("R9 idle warm keeps 7,6,3", 8'hC8);
    wrReg(1'b0, 8'h44);
    warmPulse(1'b1);
    readCtrl("R9 idle warm clears rest", 8'h40);
    wrReg(1'b0, 8'h04);
    unlockKeys();
    wrReg(1'b0, 8'h06);
    repeat (PROG) @(negedge clk);
    check("R11 done before reset", {7'b0, doneIrq}, 8'h01);
    warmPulse(1'b0);
    check("R11 done cleared by reset", {7'b0, doneIrq}, 8'h00);
  endtask

  task automatic testPor();
    wrReg(1'b0, 8'hDC);
    rstPorN = 1'b0; #1;
    readCtrl("R2 power-on clears all", 8'h00);
    @(negedge clk);
    rstPorN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk);
    testReset();
    testLayoutAndRead();
    testNoKey();
    testGoodWrite();
    testBrokenKeys();
    testBusyWrites();
    testAbort(1'b0);
    testAbort(1'b1);
    testWarmIdle();
    testPor();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule